// File: doc/BRIEF.md
# Cropping BGR-to-RGB565 Pixel Converter

This block takes a raster of 24-bit pixels from a wide source frame and keeps only one rectangle of it. It converts each kept pixel to the 16-bit RGB565 format. Source pixels arrive on a byte stream with a valid/ready handshake. Each pixel takes three bytes, and a frame-start marker travels with the first byte of a frame. The block counts the source column and row of every completed pixel. When the pixel falls inside the crop rectangle, the block packs it and places it in a registered output stage. Pixels outside the rectangle are accepted and thrown away.

The source width and the crop origin and size are taken from configuration inputs on the byte that carries the frame-start marker. They then stay fixed for the rest of that frame. The final pixel of the rectangle carries a last flag. After that pixel, the rest of the frame drains without producing output until the next frame-start. Back-pressure on the output holds off the input through its ready signal, so no pixel is lost or sent twice.

Top module: `rgb_crop565`

## Requirements
- R1: The three accepted bytes of each source pixel are taken in the order blue, green, red. A byte accepted with `s_sof` high is always the blue byte of source pixel (row 0, column 0), even if a previous pixel was left incomplete.
- R2: The output word is {red[7:3], green[7:2], blue[7:3]}: red in bits 15:11, green in bits 10:5, blue in bits 4:0. The lower bits of each colour are dropped.
- R3: Output pixel i, j (row i, column j of the crop) is source pixel row y0+i, column x0+j. Output pixels come out row by row, left to right, exactly w times h of them per frame.
- R4: Source pixels outside the crop rectangle are accepted and dropped, and `m_valid` is not raised for them.
- R5: `m_last` is high only together with `m_valid`, and only on the crop pixel at row h-1, column w-1.
- R6: After the last crop pixel, and after reset until the first frame-start, every byte is accepted and no output is produced.
- R7: Source width, origin and size are sampled when the frame-start byte is accepted. Changing those inputs later in the frame has no effect on that frame.
- R8: While `m_valid` is high and `m_ready` is low, `s_ready` is low and `m_data` and `m_last` hold. No pixel is lost or duplicated under any stall pattern.
- R9: During and right after reset, `m_valid` is low and `s_ready` is high.
- R10: `m_valid` for a kept pixel rises in the cycle after the clock edge that accepts that pixel's red byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte ready |
| s_data | input | 8 | Input byte (blue, green, red per pixel) |
| s_sof | input | 1 | Frame-start marker on the first byte of a frame |
| cfg_src_w | input | DIM_W | Source frame width in pixels (at least 1) |
| cfg_x0 | input | DIM_W | Crop origin column |
| cfg_y0 | input | DIM_W | Crop origin row |
| cfg_w | input | DIM_W | Crop width in pixels (at least 1) |
| cfg_h | input | DIM_W | Crop height in rows (at least 1) |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Output pixel ready |
| m_data | output | 16 | RGB565 pixel |
| m_last | output | 1 | Final pixel of the crop |

## Verification
The bench runs several crop geometries: an interior rectangle, one that touches the right edge of the source and spans the full width, and a single pixel at the very end of the frame. Each must produce exactly the expected pixels in order. A design with an off-by-one in the column wrap or the window compare would shift or drop a column. Random back-pressure targets a design that overwrites a held pixel or repeats one. Stray bytes before a frame-start check for a byte counter that does not resynchronise, which would scramble the colour channels. Configuration inputs are changed mid-frame to catch a design that reads them live instead of sampling them. Trailing rows after the last pixel catch a design that keeps emitting or flags `m_last` more than once.

// File: rtl/crop565_pkg.sv
package crop565_pkg;

  typedef struct packed {
    logic [7:0] red;
    logic [7:0] grn;
    logic [7:0] blu;
  } rgb24_t;

  function automatic logic [15:0] to565(input rgb24_t p);
    return {p.red[7:3], p.grn[7:2], p.blu[7:3]};
  endfunction

endpackage

// File: rtl/bgr_byte_joiner.sv
module bgr_byte_joiner
  import crop565_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       take,
  input  logic       sof,
  input  logic [7:0] byte_in,
  output logic       pix_fire,
  output rgb24_t     pix
);

  logic [1:0] phase;
  logic [7:0] blu_q, grn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 2'd0;
      blu_q <= 8'd0;
      grn_q <= 8'd0;
    end else if (take) begin
      if (sof) begin
        blu_q <= byte_in;
        phase <= 2'd1;
      end else begin
        case (phase)
          2'd0: begin blu_q <= byte_in; phase <= 2'd1; end
          2'd1: begin grn_q <= byte_in; phase <= 2'd2; end
          default: phase <= 2'd0;
        endcase
      end
    end
  end

  assign pix_fire = take && !sof && (phase == 2'd2);
  assign pix      = '{red: byte_in, grn: grn_q, blu: blu_q};

  // R1: a frame-start byte always becomes the blue byte
  assert_sof_restart_R1: assert property (@(posedge clk) disable iff (rst)
    (take && sof) |=> (phase == 2'd1));

  // R1: byte phase stays in its three legal values
  assert_phase_legal_R1: assert property (@(posedge clk) disable iff (rst)
    phase != 2'd3);

endmodule

// File: rtl/raster_tracker.sv
module raster_tracker #(
  parameter int DIM_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_sof,
  input  logic             pix_fire,
  input  logic [DIM_W-1:0] cfg_src_w,
  input  logic [DIM_W-1:0] cfg_x0,
  input  logic [DIM_W-1:0] cfg_y0,
  input  logic [DIM_W-1:0] cfg_w,
  input  logic [DIM_W-1:0] cfg_h,
  output logic             keep,
  output logic             last_px
);

  localparam int EW = DIM_W + 1;

  logic [DIM_W-1:0] row, col;
  logic [DIM_W-1:0] srcw_q, x0_q, y0_q, w_q, h_q;
  logic             active;
  logic [EW-1:0]    dx, dy;
  logic             in_x, in_y, wrap;

  always_comb begin
    dx      = {1'b0, col} - {1'b0, x0_q};
    dy      = {1'b0, row} - {1'b0, y0_q};
    in_x    = (col >= x0_q) && (dx < {1'b0, w_q});
    in_y    = (row >= y0_q) && (dy < {1'b0, h_q});
    keep    = active && in_x && in_y;
    last_px = (dx == ({1'b0, w_q} - EW'(1))) && (dy == ({1'b0, h_q} - EW'(1)));
    wrap    = ({1'b0, col} == ({1'b0, srcw_q} - EW'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      row    <= '0;
      col    <= '0;
      srcw_q <= '0;
      x0_q   <= '0;
      y0_q   <= '0;
      w_q    <= '0;
      h_q    <= '0;
    end else if (take_sof) begin
      active <= 1'b1;
      row    <= '0;
      col    <= '0;
      srcw_q <= cfg_src_w;
      x0_q   <= cfg_x0;
      y0_q   <= cfg_y0;
      w_q    <= cfg_w;
      h_q    <= cfg_h;
    end else if (pix_fire) begin
      if (wrap) begin
        col <= '0;
        row <= row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
      if (keep && last_px) active <= 1'b0;
    end
  end

  // R3: the column counter never reaches the sampled width during a frame
  assert_col_bound_R3: assert property (@(posedge clk) disable iff (rst)
    active |-> ({1'b0, col} < {1'b0, srcw_q}));

  // R6: emitting the last crop pixel ends the frame
  assert_stop_after_last_R6: assert property (@(posedge clk) disable iff (rst)
    (pix_fire && keep && last_px) |=> !active);

  // R7: window settings only move on a frame-start
  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !take_sof |=> ($stable(w_q) && $stable(h_q) && $stable(x0_q) &&
                   $stable(y0_q) && $stable(srcw_q)));

endmodule

// File: rtl/px_out_stage.sv
module px_out_stage #(
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OUT_W-1:0] din,
  input  logic             last_in,
  input  logic             m_ready,
  output logic             m_valid,
  output logic [OUT_W-1:0] m_data,
  output logic             m_last
);

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_last  <= 1'b0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_data  <= din;
      m_last  <= last_in;
    end else if (m_ready) begin
      m_valid <= 1'b0;
      m_last  <= 1'b0;
    end
  end

  // R8: a stalled pixel keeps its value until taken
  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  // R8: a new pixel never lands on an untaken one
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    load |-> (!m_valid || m_ready));

  // R5: last flag only travels with a valid pixel
  assert_last_valid_R5: assert property (@(posedge clk) disable iff (rst)
    m_last |-> m_valid);

endmodule

// File: rtl/rgb_crop565.sv
module rgb_crop565
  import crop565_pkg::*;
#(
  parameter int DIM_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  input  logic             s_sof,
  input  logic [DIM_W-1:0] cfg_src_w,
  input  logic [DIM_W-1:0] cfg_x0,
  input  logic [DIM_W-1:0] cfg_y0,
  input  logic [DIM_W-1:0] cfg_w,
  input  logic [DIM_W-1:0] cfg_h,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [15:0]      m_data,
  output logic             m_last
);

  logic   take, pix_fire, keep, last_px;
  rgb24_t pix;

  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;

  bgr_byte_joiner u_join (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .sof      (s_sof),
    .byte_in  (s_data),
    .pix_fire (pix_fire),
    .pix      (pix)
  );

  raster_tracker #(.DIM_W(DIM_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .take_sof  (take && s_sof),
    .pix_fire  (pix_fire),
    .cfg_src_w (cfg_src_w),
    .cfg_x0    (cfg_x0),
    .cfg_y0    (cfg_y0),
    .cfg_w     (cfg_w),
    .cfg_h     (cfg_h),
    .keep      (keep),
    .last_px   (last_px)
  );

  px_out_stage #(.OUT_W(16)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (pix_fire && keep),
    .din     (to565(pix)),
    .last_in (last_px),
    .m_ready (m_ready),
    .m_valid (m_valid),
    .m_data  (m_data),
    .m_last  (m_last)
  );

  // R8: input is held off while the output is stalled
  assert_backpressure_R8: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |-> !s_ready);

  // R9: reset empties the output stage
  assert_reset_idle_R9: assert property (@(posedge clk)
    rst |=> !m_valid);

endmodule

// File: tb/sim_rgb_crop565.sv
`timescale 1ns/1ps
module sim_rgb_crop565;

  localparam int DIM_W = 11;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             s_valid = 1'b0;
  logic             s_ready;
  logic [7:0]       s_data = 8'd0;
  logic             s_sof = 1'b0;
  logic [DIM_W-1:0] cfg_src_w = '0, cfg_x0 = '0, cfg_y0 = '0, cfg_w = '0, cfg_h = '0;
  logic             m_valid;
  logic             m_ready = 1'b1;
  logic [15:0]      m_data;
  logic             m_last;

  int   n_checks = 0;
  int   n_fails  = 0;
  bit   bp_en    = 1'b0;
  bit   done     = 1'b0;
  logic [16:0] exp_q[$];

  always #4 clk = ~clk;

  rgb_crop565 #(.DIM_W(DIM_W)) u0 (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_sof(s_sof), .cfg_src_w(cfg_src_w), .cfg_x0(cfg_x0), .cfg_y0(cfg_y0),
    .cfg_w(cfg_w), .cfg_h(cfg_h), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_last(m_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pk(input logic [7:0] r, g, b);
    return {r[7:3], g[7:2], b[7:3]};
  endfunction

  always @(posedge clk) begin
    #1;
    m_ready = bp_en ? (($urandom % 3) != 0) : 1'b1;
  end

  // Scoreboard monitor, sampled at the falling edge
  bit          stall_prev = 1'b0;
  logic [15:0] held_d;
  logic        held_l;
  always @(negedge clk) begin
    if (!rst) begin
      if (stall_prev)
        check(m_valid && m_data == held_d && m_last == held_l, "R8 hold",
              {m_valid, m_last, m_data}, {1'b1, held_l, held_d});
      if (m_valid && !m_ready)
        check(!s_ready, "R8 ready", s_ready, 0);
      stall_prev = m_valid && !m_ready;
      held_d = m_data;
      held_l = m_last;
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4/R6 unexpected output", {m_last, m_data}, 0);
        end else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          check({m_last, m_data} == e, "R2/R3/R5 pixel", {m_last, m_data}, e);
        end
      end
    end
  end

  task automatic send_byte(input logic [7:0] d, input bit sof);
    bit ok;
    s_valid = 1'b1;
    s_data  = d;
    s_sof   = sof;
    do begin
      @(negedge clk);
      ok = s_ready;
      @(posedge clk);
      #1;
    end while (!ok);
    s_valid = 1'b0;
    s_sof   = 1'b0;
  endtask

  task automatic send_frame(input int sw, sh, x0, y0, w, h, input bit scramble);
    cfg_src_w = DIM_W'(sw); cfg_x0 = DIM_W'(x0); cfg_y0 = DIM_W'(y0);
    cfg_w = DIM_W'(w); cfg_h = DIM_W'(h);
    for (int r = 0; r < sh; r++) begin
      for (int c = 0; c < sw; c++) begin
        logic [7:0] bb, gg, rr;
        bb = 8'($urandom); gg = 8'($urandom); rr = 8'($urandom);
        if (r >= y0 && r < y0 + h && c >= x0 && c < x0 + w)
          exp_q.push_back({(r == y0 + h - 1 && c == x0 + w - 1), pk(rr, gg, bb)});
        send_byte(bb, (r == 0 && c == 0));
        if (scramble && r == 0 && c == 0) begin  // R7: disturb config mid-frame
          cfg_src_w = DIM_W'(sw + 3); cfg_x0 = '0; cfg_y0 = '0;
          cfg_w = DIM_W'(1); cfg_h = DIM_W'(1);
        end
        send_byte(gg, 1'b0);
        send_byte(rr, 1'b0);
      end
    end
  endtask

  task automatic drain();
    repeat (40) @(posedge clk);
    #1;
    @(negedge clk);
    check(exp_q.size() == 0, "R3 count", exp_q.size(), 0);
    check(!m_valid, "R6 idle", m_valid, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check(!m_valid, "R9 valid", m_valid, 0);
    check(s_ready, "R9 ready", s_ready, 1);
    rst = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    check(!m_valid && s_ready, "R9 after", {m_valid, s_ready}, 2'b01);

    // R6: bytes before any frame-start are dropped
    for (int k = 0; k < 9; k++) send_byte(8'(k * 17), 1'b0);
    drain();

    // R10 and R2: single pixel, known values, latency
    cfg_src_w = 1; cfg_x0 = 0; cfg_y0 = 0; cfg_w = 1; cfg_h = 1;
    exp_q.push_back({1'b1, 16'h003F});
    send_byte(8'hF8, 1'b1);
    send_byte(8'h04, 1'b0);
    s_valid = 1'b1; s_data = 8'h07; s_sof = 1'b0;
    @(negedge clk);
    check(!m_valid && s_ready, "R10 before", m_valid, 0);
    @(posedge clk); #1;
    s_valid = 1'b0;
    @(negedge clk);
    check(m_valid, "R10 after", m_valid, 1);
    drain();

    // R3 R4 R5 R6: interior window, trailing rows dropped
    send_frame(8, 6, 2, 1, 4, 3, 1'b0);
    drain();

    // R1: partial pixel left before a new frame-start
    send_byte(8'h55, 1'b0);
    send_byte(8'hAA, 1'b0);

    // R8: same geometry under random back-pressure
    bp_en = 1'b1;
    send_frame(8, 6, 2, 1, 4, 3, 1'b0);
    drain();

    // R3: window on the right edge, then full width
    send_frame(8, 4, 5, 0, 3, 2, 1'b0);
    send_frame(6, 3, 0, 1, 6, 2, 1'b0);
    drain();

    // R5: single pixel at the very end of the frame
    send_frame(5, 4, 4, 3, 1, 1, 1'b0);
    drain();

    // R7: configuration changed after frame-start
    send_frame(7, 5, 1, 2, 3, 2, 1'b1);
    drain();

    bp_en = 1'b0;
    send_frame(10, 3, 3, 0, 5, 3, 1'b0);
    drain();

    finish_run();
  end

endmodule